// File: doc/BRIEF.md
# Retriggerable Hardware Strobe Counter

This block is one 16-bit timer channel that produces a single-tick low strobe a programmed number of count ticks after a hardware trigger. A trigger is a rising edge on an asynchronous gate input. The edge is synchronised to the system clock and held in a pending flag until the next count tick samples it. That tick loads the stored initial count and does not decrement it. Each later tick decrements the count, in binary or in four BCD digits. The tick that brings the count to zero drives the output low until the next tick.

Count ticks arrive as a one-cycle enable in the system clock domain. Writing a new initial value never disturbs a sequence that is already running. The new value is used at the next trigger, and a trigger during a sequence restarts it from the initial value. A control reset pulse returns the channel to its idle, output-high state. After expiry the count keeps wrapping but does not strobe again until a new trigger arrives. An initial value of zero is the largest count: 65536 in binary, 10000 in BCD.

The controller has four states. ST_IDLE waits for the first trigger. ST_RUN counts toward expiry. ST_STROBE holds the output low. ST_FREE keeps the count wrapping with no strobe. The transitions are as follows:
- load: from any state to ST_RUN, on a tick while a trigger is pending.
- expire: from ST_RUN to ST_STROBE, on a tick when the count is one.
- release: from ST_STROBE to ST_FREE, on the next tick.
- clear: from any state to ST_IDLE, on the control reset pulse.

Top module: `retrig_strobe_timer`

## Requirements
- R1: After reset or a control reset pulse, out_n is 1. It stays 1 through ticks and initial-value writes for as long as no trigger has been captured.
- R2: The first tick after a captured gate rising edge is tick 1, and it loads the initial value N. out_n goes to 0 in the cycle after tick N+1.
- R3: out_n stays 0 while no tick occurs, and it returns to 1 in the cycle after the next tick. The strobe therefore lasts exactly one tick.
- R4: A trigger captured while a sequence runs makes the next tick reload N, and the strobe then follows N+1 ticks after that reload.
- R5: An initial-value write during a sequence does not change when the current strobe comes. The new value is the one loaded by the next trigger.
- R6: A gate pulse of one system clock is captured and stays pending however long no tick comes. A gate held high causes only one trigger.
- R7: With bcd_sel = 0 the count is 16-bit binary. After a strobe the channel keeps ticking with no further strobe, and N = 0 gives 65536 decrements.
- R8: With bcd_sel = 1 the count is four BCD digits, with bits [3:0] as the least significant digit. 0x0010 means ten decrements, 0x0100 means one hundred, and 0x0000 means ten thousand.
- R9: A control reset pulse stops a running sequence and discards a pending trigger. No strobe follows until a new gate edge is captured.
- R10: out_n changes only in the cycle after a tick or a control reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | One-cycle count tick enable |
| gate_in | input | 1 | Asynchronous trigger gate; its rising edge arms the channel |
| ld_val | input | 16 | Initial count value |
| ld_we | input | 1 | Write pulse that stores ld_val |
| cfg_rst | input | 1 | Control reset pulse, returns the channel to idle |
| bcd_sel | input | 1 | 1 selects BCD counting, 0 selects binary |
| out_n | output | 1 | Strobe output, low for one tick at expiry |

## Verification
The assertions assume that cnt_en and cfg_rst are synchronous single-cycle pulses. They also assume that bcd_sel does not change while a sequence runs, and that with bcd_sel = 1 every loaded value holds valid BCD digits. The bench drives every input on the falling clock edge. It keeps bcd_sel fixed between triggers and loads only valid digit values in BCD mode. It leaves several cycles after each gate pulse so that the synchroniser can deliver the edge before any tick that is meant to sample it.

// File: rtl/strobe_timer_pkg.sv
package strobe_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_STROBE,
        ST_FREE
    } strobe_state_e;

endpackage

// File: rtl/strobe_gate_cap.sv
// Synchronises the gate, detects its rising edge and holds the trigger
// pending until a count tick samples it.
module strobe_gate_cap #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    input  logic sample,
    input  logic clr,
    output logic pend
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], gate_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (clr) begin
            pend <= 1'b0;
        end else if (rise) begin
            pend <= 1'b1;
        end else if (sample) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/strobe_cnt_dec.sv
// Combinational down-step of the count, binary or one BCD digit per nibble.
module strobe_cnt_dec #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             bcd,
    output logic [CNT_W-1:0] nxt
);

    localparam int DIGITS = CNT_W / 4;

    logic [DIGITS:0]     borrow;
    logic [CNT_W-1:0]    bcd_nxt;

    assign borrow[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] d;
        assign d = cur[4*g +: 4];
        assign borrow[g+1] = borrow[g] & (d == 4'd0);
        always_comb begin
            if (!borrow[g]) begin
                bcd_nxt[4*g +: 4] = d;
            end else if (d == 4'd0) begin
                bcd_nxt[4*g +: 4] = 4'd9;
            end else begin
                bcd_nxt[4*g +: 4] = d - 4'd1;
            end
        end
    end

    assign nxt = bcd ? bcd_nxt : (cur - {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/retrig_strobe_timer.sv
module retrig_strobe_timer
    import strobe_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             gate_in,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ld_we,
    input  logic             cfg_rst,
    input  logic             bcd_sel,
    output logic             out_n
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    strobe_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_dec;
    logic [CNT_W-1:0] init_q;
    logic             trig_pend;

    strobe_gate_cap #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_in (gate_in),
        .sample  (cnt_en),
        .clr     (cfg_rst),
        .pend    (trig_pend)
    );

    strobe_cnt_dec #(.CNT_W(CNT_W)) u_dec (
        .cur (cnt_q),
        .bcd (bcd_sel),
        .nxt (cnt_dec)
    );

    // Initial value register; only read when a trigger loads it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= '0;
        end else if (ld_we) begin
            init_q <= ld_val;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cfg_rst) begin
            state_d = ST_IDLE;
        end else if (cnt_en) begin
            if (trig_pend) begin
                cnt_d   = init_q;
                state_d = ST_RUN;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        state_d = ST_IDLE;
                    end
                    ST_RUN: begin
                        cnt_d = cnt_dec;
                        if (cnt_q == CNT_ONE) begin
                            state_d = ST_STROBE;
                        end
                    end
                    ST_STROBE: begin
                        cnt_d   = cnt_dec;
                        state_d = ST_FREE;
                    end
                    ST_FREE: begin
                        cnt_d = cnt_dec;
                    end
                    default: begin
                        state_d = ST_IDLE;
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        out_n = (state_q != ST_STROBE);
    end

endmodule

// File: rtl/retrig_strobe_timer_chk.sv
module retrig_strobe_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic cnt_en,
    input logic cfg_rst,
    input logic trig_pend,
    input logic out_n
);

    a_r1_cfg_rst_out_high: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst |=> out_n);

    a_r3_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_n && !cnt_en && !cfg_rst) |=> !out_n);

    a_r3_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_n && cnt_en) |=> out_n);

    a_r4_load_tick_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && trig_pend && !cfg_rst) |=> out_n);

    a_r6_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pend && !cnt_en && !cfg_rst) |=> trig_pend);

    a_r9_clear_drops_pend: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst |=> !trig_pend);

    a_r10_out_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_n) |-> ($past(cnt_en) || $past(cfg_rst)));

endmodule

bind retrig_strobe_timer retrig_strobe_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .cfg_rst   (cfg_rst),
    .trig_pend (trig_pend),
    .out_n     (out_n)
);

// File: tb/retrig_strobe_timer_tb.sv
module retrig_strobe_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        gate_in = 1'b0;
    logic [15:0] ld_val = '0;
    logic        ld_we = 1'b0;
    logic        cfg_rst = 1'b0;
    logic        bcd_sel = 1'b0;
    logic        out_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    retrig_strobe_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .gate_in (gate_in),
        .ld_val  (ld_val),
        .ld_we   (ld_we),
        .cfg_rst (cfg_rst),
        .bcd_sel (bcd_sel),
        .out_n   (out_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] v);
        @(negedge clk);
        ld_val = v;
        ld_we  = 1'b1;
        @(negedge clk);
        ld_we  = 1'b0;
    endtask

    task automatic trigger();
        @(negedge clk);
        gate_in = 1'b1;
        @(negedge clk);
        gate_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ctl_reset();
        @(negedge clk);
        cfg_rst = 1'b1;
        @(negedge clk);
        cfg_rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    // Ticks continuously until out_n is low; returns tick count, or -1.
    task automatic ticks_to_low(input int max, output int n);
        bit seen = 1'b0;
        @(negedge clk);
        cnt_en = 1'b1;
        n = 0;
        while (n < max && !seen) begin
            @(negedge clk);
            n++;
            if (!out_n) seen = 1'b1;
        end
        cnt_en = 1'b0;
        if (!seen) n = -1;
    endtask

    // Ticks n times and returns how many cycles showed out_n low.
    task automatic count_lows(input int n, output int lows);
        @(negedge clk);
        cnt_en = 1'b1;
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!out_n) lows++;
        end
        cnt_en = 1'b0;
    endtask

    task automatic t_reset_idle();
        int lows;
        check(out_n == 1'b1, "R1 reset", out_n, 1);
        load(16'd3);
        count_lows(20, lows);
        check(lows == 0, "R1 no trigger", lows, 0);
    endtask

    task automatic t_basic_strobe();
        int n;
        bcd_sel = 1'b0;
        load(16'd3);
        trigger();
        ticks_to_low(100, n);
        check(n == 4, "R2 N=3", n, 4);
        repeat (3) @(negedge clk);
        check(out_n == 1'b0, "R3 held low", out_n, 0);
        ticks(1);
        check(out_n == 1'b1, "R3 released", out_n, 1);
        load(16'd1);
        trigger();
        ticks_to_low(100, n);
        check(n == 2, "R2 N=1", n, 2);
        ticks(1);
    endtask

    task automatic t_wrap_no_restrobe();
        int n, lows;
        load(16'd2);
        trigger();
        ticks_to_low(100, n);
        check(n == 3, "R7 N=2", n, 3);
        count_lows(40, lows);
        check(lows == 0, "R7 no second strobe", lows, 0);
    endtask

    task automatic t_retrigger();
        int n;
        load(16'd5);
        trigger();
        ticks(3);
        check(out_n == 1'b1, "R4 mid run", out_n, 1);
        trigger();
        ticks_to_low(100, n);
        check(n == 6, "R4 restart", n, 6);
        ticks(1);
    endtask

    task automatic t_new_count();
        int n;
        load(16'd5);
        trigger();
        ticks(2);
        load(16'd2);
        ticks_to_low(100, n);
        check(n == 4, "R5 current unaffected", n, 4);
        ticks(1);
        trigger();
        ticks_to_low(100, n);
        check(n == 3, "R5 new count used", n, 3);
        ticks(1);
    endtask

    task automatic t_gate_level();
        int n, lows;
        load(16'd2);
        trigger();
        repeat (30) @(negedge clk);
        check(out_n == 1'b1, "R6 pending waits", out_n, 1);
        ticks_to_low(100, n);
        check(n == 3, "R6 short pulse", n, 3);
        ticks(1);
        @(negedge clk);
        gate_in = 1'b1;
        repeat (4) @(negedge clk);
        ticks_to_low(100, n);
        check(n == 3, "R6 level edge", n, 3);
        count_lows(30, lows);
        check(lows == 0, "R6 held high", lows, 0);
        @(negedge clk);
        gate_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_ctl_reset();
        int lows;
        load(16'd4);
        trigger();
        ticks(2);
        ctl_reset();
        count_lows(20, lows);
        check(lows == 0, "R9 running stopped", lows, 0);
        trigger();
        ctl_reset();
        count_lows(20, lows);
        check(lows == 0, "R9 pending dropped", lows, 0);
        check(out_n == 1'b1, "R1 after control reset", out_n, 1);
    endtask

    task automatic t_bcd();
        int n;
        bcd_sel = 1'b0;
        load(16'h0010);
        trigger();
        ticks_to_low(100, n);
        check(n == 17, "R7 binary 0x10", n, 17);
        ticks(1);
        bcd_sel = 1'b1;
        trigger();
        ticks_to_low(100, n);
        check(n == 11, "R8 bcd 0x0010", n, 11);
        ticks(1);
        load(16'h0100);
        trigger();
        ticks_to_low(1000, n);
        check(n == 101, "R8 bcd 0x0100", n, 101);
        ticks(1);
        load(16'h0000);
        trigger();
        ticks_to_low(20000, n);
        check(n == 10001, "R8 bcd zero", n, 10001);
        ticks(1);
    endtask

    task automatic t_binary_zero();
        int n;
        bcd_sel = 1'b0;
        load(16'h0000);
        trigger();
        ticks_to_low(70000, n);
        check(n == 65537, "R7 binary zero", n, 65537);
        ticks(1);
        check(out_n == 1'b1, "R3 after long run", out_n, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_idle();
        t_basic_strobe();
        t_wrap_no_restrobe();
        t_retrigger();
        t_new_count();
        t_gate_level();
        t_ctl_reset();
        t_bcd();
        t_binary_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule